// File: doc/BRIEF.md
# Suspend Request Handshake Controller

This controller decides when a processor core may enter a low-power suspended state and when it leaves it. An external agent asks for suspend on an active-low request pin. The pin has a weak pull-up on the board, so a floating pin reads as "no request". The core's own halt indication is a second way in. Once a suspend is wanted, the controller waits until the core has no work in flight. The three conditions are: the current instruction is done, the decoded-instruction queue is empty, and no bus cycles are pending. Only then does it drive the active-low acknowledge and gate the clocks.

Software arms the block through a configuration enable bit. Out of reset that bit is clear. While it is clear, requests and halts are ignored and the acknowledge pin is not driven: its output-enable is low, so the pin is high-impedance at the pad. Two more configuration inputs choose between two suspend depths. One choice stops only the core clock, the other stops all internal clocks. When all clocks are stopped and the low-voltage option is selected, a flag tells the system that its external clock may be stopped as well.

The controller is built around four states. RUN is normal operation. DRAIN waits for in-flight work to finish. SUSPENDED means the acknowledge is asserted and the clocks are gated. RESUME restores the clocks one cycle before the acknowledge is released. The transitions are:
- RUN→DRAIN on a request or a halt while the block is enabled.
- DRAIN→RUN when the reason for the suspend disappears.
- DRAIN→SUSPENDED once the core is idle.
- SUSPENDED→RESUME when the reason for the suspend disappears.
- RESUME→RUN unconditionally.

Top module: `susp_handshake_ctrl`

## Requirements
- R1: The request pin is active-low: a 0 on `req_in_n` means suspend is requested. It passes through a two-flop synchroniser, so a change on the pin reaches the state machine two clock edges later. During and right after reset the block is in RUN with these outputs: `ack_out_n`=1, `ack_out_oe`=0, `core_clk_en`=1, `sys_clk_en`=1, `ext_clk_stop_ok`=0.
- R2: While `cfg_en`=0 in RUN, neither a request nor `core_halt` has any effect. The acknowledge stays 1 and the clocks stay enabled.
- R3: `ack_out_oe` is 1 whenever `cfg_en`=1 or the block is outside RUN. Clearing `cfg_en` while in RUN drops `ack_out_oe` to 0 in the same cycle.
- R4: A synchronised request with `cfg_en`=1 moves RUN→DRAIN. DRAIN→SUSPENDED happens only at an edge where `instr_busy`, `queue_busy` and `bus_busy` are all 0. From that edge on, `ack_out_n` is 0.
- R5: If the synchronised request is withdrawn while in DRAIN, the block returns to RUN and the acknowledge is never asserted. Withdrawal wins over drain completion when both happen at the same edge.
- R6: `core_halt`=1 with `cfg_en`=1 in RUN also starts a suspend, and it obeys the same drain rule. A request takes priority when both are present. For a halt-started suspend, `wake_irq`=1 takes the place of request withdrawal: it returns DRAIN to RUN and moves SUSPENDED to RESUME.
- R7: In SUSPENDED, `core_clk_en`=0. Withdrawing the request moves the block to RESUME. In RESUME, `core_clk_en` is 1 while `ack_out_n` is still 0. The next edge returns the block to RUN with `ack_out_n`=1.
- R8: In SUSPENDED, `sys_clk_en` is 0 only when `cfg_all_clk`=1. With `cfg_all_clk`=0, only the core clock is stopped.
- R9: `ext_clk_stop_ok` is 1 only in SUSPENDED, only with `cfg_all_clk`=1 and `cfg_lowv`=1, and only from the second cycle of SUSPENDED onward. It therefore always follows an already asserted acknowledge.
- R10: Clearing `cfg_en` outside RUN does not abort the suspend in progress. The sequence completes normally, and `ack_out_oe` falls only once RUN is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in_n | input | 1 | Suspend request, active-low, asynchronous |
| cfg_en | input | 1 | Configuration enable for request and acknowledge |
| cfg_all_clk | input | 1 | 1: stop all internal clocks in suspend; 0: core clock only |
| cfg_lowv | input | 1 | Low-voltage suspend option |
| core_halt | input | 1 | Core has executed a halt |
| wake_irq | input | 1 | Interrupt ending a halt-started suspend |
| instr_busy | input | 1 | Current instruction still executing |
| queue_busy | input | 1 | Decoded instructions pending |
| bus_busy | input | 1 | Bus cycles pending |
| ack_out_n | output | 1 | Suspend acknowledge, active-low |
| ack_out_oe | output | 1 | Output-enable for the acknowledge pin |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | Enable for the remaining internal clocks |
| ext_clk_stop_ok | output | 1 | External system clock may be stopped |

## Verification
Two events can meet at one DRAIN edge: the synchronised request is withdrawn, and the last busy flag clears. The bench provokes this by raising the request pin two cycles before it drops the final busy flag, so that both changes reach the state machine together. It then judges the outcome by requiring a return to RUN with no acknowledge pulse at all. A second collision is also provoked: the enable bit is cleared in the middle of a suspend, and `ack_out_oe` is expected to hold until RESUME has passed. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/susp_pkg.sv
`timescale 1ns/1ps
package susp_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_DRAIN     = 2'd1,
        ST_SUSPENDED = 2'd2,
        ST_RESUME    = 2'd3
    } susp_state_e;
endpackage

// File: rtl/susp_sync.sv
`timescale 1ns/1ps
module susp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[LAST-1:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain[LAST];
endmodule

// File: rtl/susp_fsm.sv
`timescale 1ns/1ps
module susp_fsm
    import susp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_seen,
    input  logic        cfg_en,
    input  logic        core_halt,
    input  logic        wake_irq,
    input  logic        drained,
    output susp_state_e state
);
    susp_state_e state_nx;
    logic        halt_cause;
    logic        halt_cause_nx;
    logic        keep;

    // The reason for the current suspend is still present
    assign keep = halt_cause ? !wake_irq : req_seen;

    always_comb begin
        state_nx      = state;
        halt_cause_nx = halt_cause;
        unique case (state)
            ST_RUN: begin
                if (cfg_en && req_seen) begin
                    state_nx      = ST_DRAIN;
                    halt_cause_nx = 1'b0;
                end else if (cfg_en && core_halt) begin
                    state_nx      = ST_DRAIN;
                    halt_cause_nx = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!keep)        state_nx = ST_RUN;
                else if (drained) state_nx = ST_SUSPENDED;
            end
            ST_SUSPENDED: begin
                if (!keep) state_nx = ST_RESUME;
            end
            ST_RESUME: begin
                state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            halt_cause <= 1'b0;
        end else begin
            state      <= state_nx;
            halt_cause <= halt_cause_nx;
        end
    end

    // R5: a withdrawn request in DRAIN leads straight back to RUN
    p_withdraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !halt_cause && !req_seen) |=> state == ST_RUN);

    // R6: a wake interrupt ends a halt-started suspension
    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPENDED && halt_cause && wake_irq) |=> state == ST_RESUME);
endmodule

// File: rtl/susp_clk_ctl.sv
`timescale 1ns/1ps
module susp_clk_ctl
    import susp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  susp_state_e state,
    input  logic        cfg_all_clk,
    input  logic        cfg_lowv,
    output logic        core_clk_en,
    output logic        sys_clk_en,
    output logic        ext_clk_stop_ok
);
    logic in_susp;
    logic in_susp_q;

    assign in_susp = (state == ST_SUSPENDED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_susp_q <= 1'b0;
        else        in_susp_q <= in_susp;
    end

    always_comb begin
        core_clk_en     = !in_susp;
        sys_clk_en      = !(in_susp && cfg_all_clk);
        ext_clk_stop_ok = in_susp && in_susp_q && cfg_all_clk && cfg_lowv;
    end
endmodule

// File: rtl/susp_handshake_ctrl.sv
`timescale 1ns/1ps
module susp_handshake_ctrl
    import susp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in_n,
    input  logic cfg_en,
    input  logic cfg_all_clk,
    input  logic cfg_lowv,
    input  logic core_halt,
    input  logic wake_irq,
    input  logic instr_busy,
    input  logic queue_busy,
    input  logic bus_busy,
    output logic ack_out_n,
    output logic ack_out_oe,
    output logic core_clk_en,
    output logic sys_clk_en,
    output logic ext_clk_stop_ok
);
    susp_state_e state;
    logic        req_seen;
    logic        drained;

    assign drained = !(instr_busy || queue_busy || bus_busy);

    susp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (!req_in_n),
        .q_out (req_seen)
    );

    susp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_seen  (req_seen),
        .cfg_en    (cfg_en),
        .core_halt (core_halt),
        .wake_irq  (wake_irq),
        .drained   (drained),
        .state     (state)
    );

    susp_clk_ctl u_clk (
        .clk             (clk),
        .rst_n           (rst_n),
        .state           (state),
        .cfg_all_clk     (cfg_all_clk),
        .cfg_lowv        (cfg_lowv),
        .core_clk_en     (core_clk_en),
        .sys_clk_en      (sys_clk_en),
        .ext_clk_stop_ok (ext_clk_stop_ok)
    );

    always_comb begin
        ack_out_n  = !(state == ST_SUSPENDED || state == ST_RESUME);
        ack_out_oe = cfg_en || (state != ST_RUN);
    end

    // R4: the acknowledge only falls after an idle core
    p_ack_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_out_n) |-> $past(drained));

    // R2: nothing starts while disabled in RUN
    p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !cfg_en) |=> ack_out_n);

    // R3: an asserted acknowledge is always driven
    p_ack_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_out_n |-> ack_out_oe);

    // R7: clock restarts while ack is still low, ack releases next cycle
    p_resume_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (!ack_out_n ##1 ack_out_n));

    // R8: clocks are only gated under an asserted acknowledge
    p_gate_under_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en || !sys_clk_en) |-> !ack_out_n);

    // R9: external clock stop permission follows an earlier acknowledge
    p_ext_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_clk_stop_ok) |-> $past(!ack_out_n));
endmodule

// File: tb/sim_susp_handshake_ctrl.sv
`timescale 1ns/1ps
module sim_susp_handshake_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_in_n = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_all_clk = 1'b0;
    logic cfg_lowv = 1'b0;
    logic core_halt = 1'b0;
    logic wake_irq = 1'b0;
    logic instr_busy = 1'b0;
    logic queue_busy = 1'b0;
    logic bus_busy = 1'b0;
    logic ack_out_n, ack_out_oe, core_clk_en, sys_clk_en, ext_clk_stop_ok;

    int checks = 0;
    int fails = 0;
    logic ack_seen = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    susp_handshake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_in_n(req_in_n), .cfg_en(cfg_en),
        .cfg_all_clk(cfg_all_clk), .cfg_lowv(cfg_lowv), .core_halt(core_halt),
        .wake_irq(wake_irq), .instr_busy(instr_busy), .queue_busy(queue_busy),
        .bus_busy(bus_busy), .ack_out_n(ack_out_n), .ack_out_oe(ack_out_oe),
        .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
        .ext_clk_stop_ok(ext_clk_stop_ok)
    );

    // Behavioural reference model: 0 run, 1 drain, 2 suspended, 3 resume
    int  m_st = 0;
    bit  m_halt = 0;
    bit  m_s1 = 0, m_s2 = 0, m_prev_susp = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_halt = 0; m_s1 = 0; m_s2 = 0; m_prev_susp = 0;
        end else begin
            int  nst;
            bit  nh, still, idle;
            nst = m_st; nh = m_halt;
            still = m_halt ? !wake_irq : m_s2;
            idle = !instr_busy && !queue_busy && !bus_busy;
            if (m_st == 0) begin
                if (cfg_en && m_s2) begin nst = 1; nh = 0; end
                else if (cfg_en && core_halt) begin nst = 1; nh = 1; end
            end else if (m_st == 1) begin
                if (!still) nst = 0;
                else if (idle) nst = 2;
            end else if (m_st == 2) begin
                if (!still) nst = 3;
            end else begin
                nst = 0;
            end
            m_prev_susp = (m_st == 2);
            m_st = nst; m_halt = nh;
            m_s2 = m_s1; m_s1 = !req_in_n;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model on every clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        chk("R4 ack_out_n", ack_out_n, !(m_st == 2 || m_st == 3));
        chk("R3 ack_out_oe", ack_out_oe, cfg_en || (m_st != 0));
        chk("R7 core_clk_en", core_clk_en, m_st != 2);
        chk("R8 sys_clk_en", sys_clk_en, !(m_st == 2 && cfg_all_clk));
        chk("R9 ext_clk_stop_ok", ext_clk_stop_ok,
            (m_st == 2) && m_prev_susp && cfg_all_clk && cfg_lowv);
        if (!ack_out_n) ack_seen = 1'b1;
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_600_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 reset ack", ack_out_n, 1'b1);
        chk("R1 reset oe", ack_out_oe, 1'b0);
        chk("R1 reset clk", core_clk_en, 1'b1);
        rst_n = 1'b1;
        tick(2);

        // R2: disabled block ignores request and halt
        req_in_n = 1'b0; core_halt = 1'b1; ack_seen = 0;
        tick(10);
        chk("R2 no ack while disabled", ack_seen, 1'b0);
        chk("R2 oe low while disabled", ack_out_oe, 1'b0);
        req_in_n = 1'b1; core_halt = 1'b0;
        tick(4);

        // R4/R8/R9: request with staged drain, all clocks and low-voltage
        cfg_en = 1'b1; cfg_all_clk = 1'b1; cfg_lowv = 1'b1;
        instr_busy = 1; queue_busy = 1; bus_busy = 1;
        tick(1);
        chk("R3 oe follows enable", ack_out_oe, 1'b1);
        req_in_n = 1'b0;
        tick(8);
        chk("R4 waits for busy", ack_out_n, 1'b1);
        instr_busy = 0; tick(2);
        queue_busy = 0; tick(2);
        chk("R4 waits for bus", ack_out_n, 1'b1);
        bus_busy = 0; tick(3);
        chk("R4 ack after drain", ack_out_n, 1'b0);
        chk("R9 ext stop allowed", ext_clk_stop_ok, 1'b1);
        req_in_n = 1'b1;
        tick(6);
        chk("R7 back to run", ack_out_n, 1'b1);

        // R5: withdrawal during drain
        bus_busy = 1; ack_seen = 0;
        req_in_n = 1'b0; tick(5);
        req_in_n = 1'b1; tick(5);
        bus_busy = 0; tick(3);
        chk("R5 no ack on withdrawal", ack_seen, 1'b0);

        // R5: withdrawal and drain completion reach the FSM together
        bus_busy = 1; ack_seen = 0;
        req_in_n = 1'b0; tick(5);
        req_in_n = 1'b1; tick(2);
        bus_busy = 0; tick(5);
        chk("R5 withdrawal wins same edge", ack_seen, 1'b0);

        // R6/R8: halt-started suspend, core clock only
        cfg_all_clk = 1'b0; ack_seen = 0;
        core_halt = 1'b1; tick(4);
        chk("R6 halt acknowledged", ack_seen, 1'b1);
        chk("R8 system clock kept", sys_clk_en, 1'b1);
        tick(3);
        wake_irq = 1'b1; core_halt = 1'b0; tick(1);
        wake_irq = 1'b0; tick(3);
        chk("R6 wake resumes", ack_out_n, 1'b1);

        // R10: clearing enable during suspension does not abort it
        cfg_all_clk = 1'b1; cfg_lowv = 1'b0;
        req_in_n = 1'b0; tick(6);
        cfg_en = 1'b0; tick(3);
        chk("R10 oe held during suspend", ack_out_oe, 1'b1);
        chk("R10 still suspended", ack_out_n, 1'b0);
        chk("R9 no ext stop without lowv", ext_clk_stop_ok, 1'b0);
        req_in_n = 1'b1; tick(6);
        chk("R10 oe drops in run", ack_out_oe, 1'b0);
        chk("R3 released oe", ack_out_oe, 1'b0);

        // R2: request while disabled after a completed suspend
        ack_seen = 0; req_in_n = 1'b0; tick(8);
        chk("R2 ignored after clear", ack_seen, 1'b0);
        req_in_n = 1'b1; tick(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule